// File: doc/BRIEF.md
# Reset Source Capture Controller

This block collects every reason the chip may need a reset, turns them into one synchronous system reset, and keeps a small status byte that tells software which source produced the most recent reset. Five sources are handled: power-on, a low-voltage trip, a clock-generator fault, a CPU access to an unmapped address, and a reset forced from the debug port.

The block watches the CPU address bus and its access strobe. Any access that lands inside one of two fixed address gaps is treated as illegal. Addresses in the register areas are never flagged, even where a slot is unused or reserved. A low-voltage trip produces a reset only when both of its enable inputs are set. The force-reset register holds a single control bit, and only the debug write port can write it. CPU writes to it change nothing, and a CPU read of it returns zero.

The system reset stays asserted for a fixed number of cycles after the last request cycle and is then released on a clock edge. The status byte survives the reset it records. It is rewritten only when the next reset event begins.

Top module: `reset_cause_unit`

## Requirements
- R1: While `porReq` is high, `sysRst` is asserted on the following edge. The status byte then reads 0x02, with bit 1 set because power-on shares the low-voltage flag.
- R2: `sysRst` rises on the first rising edge that samples any request. It falls on the HOLD_CYCLES-th rising edge after the last edge that sampled a request.
- R3: A CPU access (`cpuValid`=1, read or write) to an address from 0x0470 to 0x17FF, or from 0x1860 to 0xBFFF, both ranges inclusive, causes a reset. After it the status byte reads 0x08 (bit 3).
- R4: A CPU access outside both gaps causes no reset and leaves the status byte unchanged. This includes 0x046F, the register area 0x1800–0x185F and its reserved slots, and 0xC000.
- R5: A low-voltage reset occurs only when `lvdTrip`, `lvdRstEn` and `lvdStopEn` are all 1. The status byte then reads 0x02. If either enable is 0, the trip has no effect.
- R6: A high `clkFault` causes a reset, and the status byte then reads 0x04 (bit 2).
- R7: When several sources request in the same cycle, the status byte holds the OR of all their bits.
- R8: A debug write (`dbgWrite`=1) to address 0x1801 with `dbgWbit`=1 forces a reset, after which the status byte reads 0x00. The same write with `dbgWbit`=0, or to any other address, has no effect.
- R9: CPU writes to 0x1801 are ignored. A CPU read of 0x1801 returns 0x00.
- R10: A CPU read (`cpuValid`=1, `cpuWrite`=0) of 0x1800 returns the status byte, and reads of other addresses return 0x00. The status byte changes only at the start of a reset event. CPU writes to 0x1800 do not change it.
- R11: CPU accesses made while `sysRst` is high are not checked against the gaps, so they neither extend the reset nor alter the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porReq | input | 1 | Power-on reset request |
| lvdTrip | input | 1 | Low-voltage trip flag from the analog sensor |
| lvdRstEn | input | 1 | Low-voltage reset enable |
| lvdStopEn | input | 1 | Low-voltage enable for stop mode |
| clkFault | input | 1 | Clock-generator fault request |
| cpuValid | input | 1 | CPU access strobe |
| cpuWrite | input | 1 | CPU access is a write |
| cpuAddr | input | 16 | CPU address |
| cpuRdata | output | 8 | CPU read data (status byte or zero) |
| dbgWrite | input | 1 | Debug port write strobe |
| dbgAddr | input | 16 | Debug port write address |
| dbgWbit | input | 1 | Debug write data, bit 0 |
| sysRst | output | 1 | Synchronous system reset |

## Verification
The bench builds the block with HOLD_CYCLES set to 6 and keeps the default gap bounds and register addresses. The short hold lets a run contain dozens of complete reset events, each with its pulse width counted exactly. The default bounds keep every gap edge (0x046F/0x0470, 0x17FF/0x1800, 0x185F/0x1860, 0xBFFF/0xC000) within the directed and random address picks. Randomly mixed sources, including same-cycle combinations and debug writes to nearby addresses, exercise the way status bits merge.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

  // One bit per reset source, as seen in a single cycle.
  typedef struct packed {
    logic por;
    logic lvd;
    logic clkFlt;
    logic illAddr;
    logic dbgForce;
  } rcuReq_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;    // load the status byte this edge
    logic rstActive;  // system reset currently asserted
  } rcuStrobe_t;

  // Status byte layout.
  localparam int ST_ILL = 3;
  localparam int ST_CLK = 2;
  localparam int ST_LVD = 1;

endpackage

// File: rtl/rcu_datapath.sv
module rcu_datapath
  import rcu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NUM_GAPS = 2,
  parameter logic [NUM_GAPS*ADDR_W-1:0] GAP_LO = {16'h1860, 16'h0470},
  parameter logic [NUM_GAPS*ADDR_W-1:0] GAP_HI = {16'hBFFF, 16'h17FF},
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h1800,
  parameter logic [ADDR_W-1:0] FORCE_ADDR = 16'h1801
) (
  input  logic              clk,
  input  logic              porReq,
  input  logic              lvdTrip,
  input  logic              lvdRstEn,
  input  logic              lvdStopEn,
  input  logic              clkFault,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              dbgWrite,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic              dbgWbit,
  input  rcuStrobe_t        strb,
  output rcuReq_t           req,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] cpuRdata
);

  logic [NUM_GAPS-1:0] gapHit;
  logic [DATA_W-1:0]   newStatus;

  // One range comparator per unmapped gap.
  for (genvar g = 0; g < NUM_GAPS; g++) begin : g_gap
    localparam logic [ADDR_W-1:0] LO = GAP_LO[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] HI = GAP_HI[g*ADDR_W +: ADDR_W];
    assign gapHit[g] = (cpuAddr >= LO) && (cpuAddr <= HI);
  end

  // Request vector. The CPU is held while reset is active, so its accesses are not judged then.
  always_comb begin
    req.por      = porReq;
    req.lvd      = lvdTrip && lvdRstEn && lvdStopEn;
    req.clkFlt   = clkFault;
    req.illAddr  = cpuValid && !strb.rstActive && (|gapHit);
    req.dbgForce = dbgWrite && (dbgAddr == FORCE_ADDR) && dbgWbit;
  end

  // Status image: power-on and low-voltage share one flag, a debug force sets none.
  always_comb begin
    newStatus         = '0;
    newStatus[ST_ILL] = req.illAddr;
    newStatus[ST_CLK] = req.clkFlt;
    newStatus[ST_LVD] = req.por || req.lvd;
  end

  // The status byte has no reset of its own and lives across the reset it records.
  always_ff @(posedge clk) begin
    if (strb.capture) statusQ <= newStatus;
  end

  // Read path: only the status byte is visible. The force register and all else read zero.
  always_comb begin
    cpuRdata = '0;
    if (cpuValid && !cpuWrite && (cpuAddr == STAT_ADDR)) cpuRdata = statusQ;
  end

endmodule

// File: rtl/rcu_ctrl.sv
module rcu_ctrl
  import rcu_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic       clk,
  input  rcuReq_t    req,
  output rcuStrobe_t strb,
  output logic       sysRst
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

  logic             anyReq;
  logic             prevReqQ;
  logic [CNT_W-1:0] holdQ;

  assign anyReq = |req;

  // Requests still high from the previous cycle continue the same event.
  // Power-on always restarts the event so the status byte is defined from the first edge.
  always_ff @(posedge clk) begin
    prevReqQ <= anyReq;
  end

  always_ff @(posedge clk) begin
    if (anyReq)            holdQ <= CNT_W'(HOLD_CYCLES);
    else if (holdQ != '0)  holdQ <= holdQ - 1'b1;
  end

  assign sysRst         = (holdQ != '0);
  assign strb.capture   = anyReq && (req.por || !prevReqQ);
  assign strb.rstActive = sysRst;

endmodule

// File: rtl/reset_cause_unit.sv
module reset_cause_unit
  import rcu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int HOLD_CYCLES = 16,
  parameter int NUM_GAPS = 2,
  parameter logic [NUM_GAPS*ADDR_W-1:0] GAP_LO = {16'h1860, 16'h0470},
  parameter logic [NUM_GAPS*ADDR_W-1:0] GAP_HI = {16'hBFFF, 16'h17FF},
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h1800,
  parameter logic [ADDR_W-1:0] FORCE_ADDR = 16'h1801
) (
  input  logic              clk,
  input  logic              porReq,
  input  logic              lvdTrip,
  input  logic              lvdRstEn,
  input  logic              lvdStopEn,
  input  logic              clkFault,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic              dbgWrite,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic              dbgWbit,
  output logic              sysRst
);

  rcuReq_t           req;
  rcuStrobe_t        strb;
  logic [DATA_W-1:0] statusQ;

  rcu_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_GAPS(NUM_GAPS),
    .GAP_LO(GAP_LO), .GAP_HI(GAP_HI),
    .STAT_ADDR(STAT_ADDR), .FORCE_ADDR(FORCE_ADDR)
  ) u_dp (
    .clk(clk), .porReq(porReq), .lvdTrip(lvdTrip), .lvdRstEn(lvdRstEn),
    .lvdStopEn(lvdStopEn), .clkFault(clkFault), .cpuValid(cpuValid),
    .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .dbgWrite(dbgWrite),
    .dbgAddr(dbgAddr), .dbgWbit(dbgWbit), .strb(strb), .req(req),
    .statusQ(statusQ), .cpuRdata(cpuRdata)
  );

  rcu_ctrl #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_ctrl (
    .clk(clk), .req(req), .strb(strb), .sysRst(sysRst)
  );

endmodule

// File: rtl/rcu_checker.sv
module rcu_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int HOLD_CYCLES = 16,
  parameter int NUM_GAPS = 2,
  parameter logic [NUM_GAPS*ADDR_W-1:0] GAP_LO = {16'h1860, 16'h0470},
  parameter logic [NUM_GAPS*ADDR_W-1:0] GAP_HI = {16'hBFFF, 16'h17FF},
  parameter logic [ADDR_W-1:0] FORCE_ADDR = 16'h1801
) (
  input logic              clk,
  input logic              porReq,
  input logic              lvdTrip,
  input logic              lvdRstEn,
  input logic              lvdStopEn,
  input logic              clkFault,
  input logic              cpuValid,
  input logic              cpuWrite,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [DATA_W-1:0] cpuRdata,
  input logic              dbgWrite,
  input logic [ADDR_W-1:0] dbgAddr,
  input logic              dbgWbit,
  input logic              sysRst,
  input logic [DATA_W-1:0] statusQ
);

  localparam int Q_W = $clog2(HOLD_CYCLES + 1);

  logic [NUM_GAPS-1:0] inGap;
  for (genvar g = 0; g < NUM_GAPS; g++) begin : g_chk
    assign inGap[g] = (cpuAddr >= GAP_LO[g*ADDR_W +: ADDR_W]) &&
                      (cpuAddr <= GAP_HI[g*ADDR_W +: ADDR_W]);
  end

  logic illSeen, reqSeen;
  assign illSeen = cpuValid && !sysRst && (|inGap);
  assign reqSeen = porReq || clkFault || (lvdTrip && lvdRstEn && lvdStopEn) || illSeen ||
                   (dbgWrite && (dbgAddr == FORCE_ADDR) && dbgWbit);

  logic started = 1'b0;
  always_ff @(posedge clk) started <= started || porReq;

  // Edges since the last sampled request, saturating at the hold length.
  logic [Q_W-1:0] quietQ = '0;
  always_ff @(posedge clk) begin
    if (reqSeen)                          quietQ <= '0;
    else if (quietQ < Q_W'(HOLD_CYCLES))  quietQ <= quietQ + 1'b1;
  end

  p_req_rise_r2: assert property (@(posedge clk) disable iff (!started)
    reqSeen |=> sysRst);

  p_release_len_r2: assert property (@(posedge clk) disable iff (!started)
    $fell(sysRst) |-> (quietQ == Q_W'(HOLD_CYCLES)));

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!started)
    (!sysRst && !reqSeen) |=> !sysRst);

  p_status_hold_r10: assert property (@(posedge clk) disable iff (!started)
    !reqSeen |=> $stable(statusQ));

  p_illegal_flag_r3: assert property (@(posedge clk) disable iff (!started)
    illSeen |=> statusQ[3]);

  p_force_reads_zero_r9: assert property (@(posedge clk) disable iff (!started)
    (cpuValid && !cpuWrite && cpuAddr == FORCE_ADDR) |-> (cpuRdata == '0));

  p_por_flag_r1: assert property (@(posedge clk) disable iff (!started)
    porReq |=> (sysRst && statusQ[1]));

endmodule

bind reset_cause_unit rcu_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOLD_CYCLES(HOLD_CYCLES),
  .NUM_GAPS(NUM_GAPS), .GAP_LO(GAP_LO), .GAP_HI(GAP_HI), .FORCE_ADDR(FORCE_ADDR)
) u_chk (
  .clk(clk), .porReq(porReq), .lvdTrip(lvdTrip), .lvdRstEn(lvdRstEn),
  .lvdStopEn(lvdStopEn), .clkFault(clkFault), .cpuValid(cpuValid),
  .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuRdata(cpuRdata),
  .dbgWrite(dbgWrite), .dbgAddr(dbgAddr), .dbgWbit(dbgWbit),
  .sysRst(sysRst), .statusQ(statusQ)
);

// File: tb/sim_reset_cause_unit.sv
`timescale 1ns/1ps
module sim_reset_cause_unit;

  localparam int HOLD = 6;
  localparam logic [15:0] STAT = 16'h1800;
  localparam logic [15:0] FRC  = 16'h1801;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        porReq, lvdTrip, lvdRstEn, lvdStopEn, clkFault;
  logic        cpuValid, cpuWrite, dbgWrite, dbgWbit;
  logic [15:0] cpuAddr, dbgAddr;
  logic [7:0]  cpuRdata;
  logic        sysRst;

  int checks = 0;
  int failures = 0;
  logic [7:0] stExp = 8'h00;

  reset_cause_unit #(.HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .porReq(porReq), .lvdTrip(lvdTrip), .lvdRstEn(lvdRstEn),
    .lvdStopEn(lvdStopEn), .clkFault(clkFault), .cpuValid(cpuValid),
    .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuRdata(cpuRdata),
    .dbgWrite(dbgWrite), .dbgAddr(dbgAddr), .dbgWbit(dbgWbit), .sysRst(sysRst)
  );

  function automatic bit isGap(input logic [15:0] a);
    return ((a >= 16'h0470) && (a <= 16'h17FF)) || ((a >= 16'h1860) && (a <= 16'hBFFF));
  endfunction

  function automatic logic [7:0] statusOf(input bit por, input bit lvd, input bit cf, input bit ill);
    return {4'b0, ill, cf, (por | lvd), 1'b0};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    porReq = 0; lvdTrip = 0; lvdRstEn = 0; lvdStopEn = 0; clkFault = 0;
    cpuValid = 0; cpuWrite = 0; cpuAddr = 16'h0000;
    dbgWrite = 0; dbgAddr = 16'h0000; dbgWbit = 0;
  endtask

  // Drive one cycle of stimulus, starting and ending at a falling edge.
  task automatic fire(input bit por, input bit lt, input bit e1, input bit e2, input bit cf,
                      input bit cv, input bit cw, input logic [15:0] ca,
                      input bit dw, input logic [15:0] da, input bit db);
    porReq = por; lvdTrip = lt; lvdRstEn = e1; lvdStopEn = e2; clkFault = cf;
    cpuValid = cv; cpuWrite = cw; cpuAddr = ca;
    dbgWrite = dw; dbgAddr = da; dbgWbit = db;
    @(posedge clk);
    @(negedge clk);
    clearIn();
  endtask

  task automatic readStatus(output logic [7:0] v);
    cpuValid = 1; cpuWrite = 0; cpuAddr = STAT;
    #1 v = cpuRdata;
    cpuValid = 0; cpuAddr = 16'h0000;
  endtask

  // Called at the falling edge right after the last request edge.
  task automatic expectOutcome(input bit expRst, input logic [7:0] expSt, input int expWidth,
                               input string tag);
    logic [7:0] rd;
    if (expRst) begin
      int width = 0;
      while (sysRst && width < 200) begin
        width++;
        @(negedge clk);
      end
      check(width == expWidth, {tag, " R2 reset width"}, width, expWidth);
      stExp = expSt;
    end else begin
      check(!sysRst, {tag, " no reset"}, sysRst, 0);
      repeat (2) @(negedge clk);
      check(!sysRst, {tag, " no reset later"}, sysRst, 0);
    end
    readStatus(rd);
    check(rd == stExp, {tag, " status"}, rd, stExp);
  endtask

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd20240611));
    clearIn();
    // R1: power-on held for three edges
    porReq = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sysRst, "R1 reset during power-on", sysRst, 1);
    porReq = 0;
    expectOutcome(1, 8'h02, HOLD, "R1 power-on");

    // R3: every gap edge is illegal
    expectOutcomeIll(16'h0470);
    expectOutcomeIll(16'h17FF);
    expectOutcomeIll(16'h1860);
    expectOutcomeIll(16'hBFFF);

    // R4: neighbours of the gaps and reserved register slots are legal
    fire(0,0,0,0,0, 1,0,16'h046F, 0,0,0); expectOutcome(0, 0, 0, "R4 0x046F");
    fire(0,0,0,0,0, 1,1,16'h1800, 0,0,0); expectOutcome(0, 0, 0, "R4 R10 write status");
    fire(0,0,0,0,0, 1,0,16'h185F, 0,0,0); expectOutcome(0, 0, 0, "R4 0x185F");
    fire(0,0,0,0,0, 1,1,16'hC000, 0,0,0); expectOutcome(0, 0, 0, "R4 0xC000");

    // R5: low-voltage gating
    fire(0,1,1,0,0, 0,0,0, 0,0,0); expectOutcome(0, 0, 0, "R5 stop enable low");
    fire(0,1,0,1,0, 0,0,0, 0,0,0); expectOutcome(0, 0, 0, "R5 reset enable low");
    fire(0,1,1,1,0, 0,0,0, 0,0,0); expectOutcome(1, 8'h02, HOLD, "R5 trip");

    // R6: clock fault
    fire(0,0,0,0,1, 0,0,0, 0,0,0); expectOutcome(1, 8'h04, HOLD, "R6 clock fault");

    // R7: simultaneous sources
    fire(0,0,0,0,1, 1,0,16'h2000, 0,0,0); expectOutcome(1, 8'h0C, HOLD, "R7 clk+ill");
    fire(0,1,1,1,1, 1,1,16'h0500, 0,0,0); expectOutcome(1, 8'h0E, HOLD, "R7 all three");

    // R8: debug force
    fire(0,0,0,0,0, 0,0,0, 1,FRC,0); expectOutcome(0, 0, 0, "R8 force bit zero");
    fire(0,0,0,0,0, 0,0,0, 1,16'h1802,1); expectOutcome(0, 0, 0, "R8 other address");
    fire(0,0,0,0,0, 0,0,0, 1,FRC,1); expectOutcome(1, 8'h00, HOLD, "R8 force");

    // R9: CPU writes to the force register are ignored, reads give zero
    fire(0,0,0,0,1, 0,0,0, 0,0,0); expectOutcome(1, 8'h04, HOLD, "R9 setup");
    fire(0,0,0,0,0, 1,1,FRC, 0,0,0); expectOutcome(0, 0, 0, "R9 cpu write force");
    cpuValid = 1; cpuWrite = 0; cpuAddr = FRC;
    #1 check(cpuRdata == 8'h00, "R9 force reads zero", cpuRdata, 0);
    cpuAddr = 16'h0080;
    #1 check(cpuRdata == 8'h00, "R10 other address reads zero", cpuRdata, 0);
    clearIn();

    // R11: illegal access during reset is not judged
    fire(0,0,0,0,1, 0,0,0, 0,0,0);
    check(sysRst, "R11 reset active", sysRst, 1);
    fire(0,0,0,0,0, 1,0,16'h3000, 0,0,0);
    expectOutcome(1, 8'h04, HOLD-1, "R11 access in reset");

    // Random mix
    for (int i = 0; i < 40; i++) begin
      bit lt, e1, e2, cf, cv, cw, dw, db, lvd, ill, frc, anyR;
      logic [15:0] ca, da;
      logic [15:0] edgesL [8] = '{16'h046F,16'h0470,16'h17FF,16'h1800,16'h185F,16'h1860,16'hBFFF,16'hC000};
      lt = $urandom_range(0,1); e1 = $urandom_range(0,1); e2 = $urandom_range(0,1);
      cf = ($urandom_range(0,7) == 0);
      cv = $urandom_range(0,1); cw = $urandom_range(0,1);
      ca = ($urandom_range(0,3) == 0) ? edgesL[$urandom_range(0,7)] : 16'($urandom);
      dw = ($urandom_range(0,3) == 0); db = $urandom_range(0,1);
      da = $urandom_range(0,1) ? FRC : 16'(16'h1800 + $urandom_range(0,3));
      lvd = lt && e1 && e2;
      ill = cv && isGap(ca);
      frc = dw && (da == FRC) && db;
      anyR = lvd || cf || ill || frc;
      fire(0,lt,e1,e2,cf, cv,cw,ca, dw,da,db);
      expectOutcome(anyR, statusOf(0, lvd, cf, ill), HOLD, $sformatf("R7 random %0d", i));
    end

    // R1 again: power-on after other events resets the status
    fire(1,0,0,0,0, 0,0,0, 0,0,0); expectOutcome(1, 8'h02, HOLD, "R1 second power-on");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic expectOutcomeIll(input logic [15:0] a);
    fire(0,0,0,0,0, 1,0,a, 0,0,0);
    expectOutcome(1, 8'h08, HOLD, $sformatf("R3 gap 0x%04h", a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule